// File: doc/BRIEF.md
# Asynchronous Serial Adapter

A byte-wide, register-mapped asynchronous serial transmitter and receiver. A host writes an 8-bit control word and a transmit data byte, and reads an 8-bit status word and the received byte. The block sends serial frames on `tx_o` and samples frames on `rx_i`. Bit timing comes from an external clock enable, which the control word divides by 1, 16 or 64.

One select line picks the register. With `sel_i` = 0 a write goes to the control register and a read returns status. With `sel_i` = 1 a write goes to the transmit data register and a read returns the received byte. Only reading the received byte has a side effect. Read data is combinational from `sel_i`, and writes and read side effects take effect at the rising clock edge. The block also drives a request-to-send pin and an interrupt request, and reports the clear-to-send and carrier-detect inputs in its status.

Top module: `async_serial_adapter`

## Requirements
- R1: The control register resets to 0x03. Until the control register is written with a divide code other than 3, the block is held in master reset: status reads 0x02 with bits 2 and 3 following the carrier and clear-to-send inputs, `tx_o` is high, and writes to the transmit data register are ignored.
- R2: Control bits [1:0] set the number of clock enables per serial bit: 0 gives 1, 1 gives 16 and 2 gives 64. Writing code 3 enters master reset. Master reset clears receive-full, overrun, framing error and parity error, sets transmit-empty, and returns both shifters to idle.
- R3: Control bits [4:2] set the character format as (data bits, parity, stop bits): 0 = 7/even/2, 1 = 7/odd/2, 2 = 7/even/1, 3 = 7/odd/1, 4 = 8/none/2, 5 = 8/none/1, 6 = 8/even/1, 7 = 8/odd/1.
- R4: A transmitted frame is one low start bit, then the data bits least significant first, then the parity bit when the format has one, then one or two high stop bits. Even parity makes the number of ones in data plus parity even, and odd parity makes it odd. Each bit lasts the divide count of clock enables, and `tx_o` idles high.
- R5: Writing the transmit data register clears transmit-empty (status bit 1). At a clock enable where the shifter is idle and `cts_n_i` is low, the byte moves into the shifter, transmit-empty is set again, and the start bit appears on `tx_o` at that same edge. While `cts_n_i` is high, the byte waits and transmit-empty stays clear.
- R6: Control bits [6:5] select the transmit control. Code 2 drives `rts_o` high; codes 0, 1 and 3 drive it low. Code 1 enables the transmit interrupt. Code 3 forces `tx_o` low (break) outside master reset.
- R7: In divide-16 and divide-64 modes, the receiver detects a high-to-low edge on the line, confirms the start bit half a bit later, and then samples each bit at its centre. In divide-1 mode it takes one sample per clock enable. For 7-bit formats, the received byte has bit 7 read as 0.
- R8: A received character whose first stop bit samples low sets the framing error flag (status bit 4). A parity mismatch sets the parity error flag (status bit 6). In both cases the character is still stored and receive-full (status bit 0) is set.
- R9: If a character completes while receive-full is still set, the overrun flag (status bit 5) is set, the new character is discarded, and the stored byte is kept.
- R10: Reading the receive data register clears receive-full, overrun, framing error and parity error.
- R11: The status word is {irq, parity error, overrun, framing error, `cts_n_i`, `dcd_n_i`, transmit-empty, receive-full}, from bit 7 down to bit 0.
- R12: `irq_o` and status bit 7 are high when control bit 7 (receive interrupt enable) is set and any of receive-full, overrun, framing error or parity error is set. They are also high when transmit-empty is set with transmit control code 1. Otherwise they are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clk_en_i | input | 1 | Serial clock enable, one pulse per serial clock tick |
| sel_i | input | 1 | Register select: 0 control/status, 1 transmit/receive data |
| wr_i | input | 1 | Register write strobe |
| rd_i | input | 1 | Register read strobe (side effect on receive data only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, status or received byte |
| rx_i | input | 1 | Serial receive line |
| tx_o | output | 1 | Serial transmit line |
| rts_o | output | 1 | Request-to-send pin level |
| cts_n_i | input | 1 | Clear-to-send, low allows transmission |
| dcd_n_i | input | 1 | Carrier detect level |
| irq_o | output | 1 | Interrupt request, active high |

## Verification
The start bit of a written byte is due at the first clock-enable edge after the write, and each later bit follows after exactly the divide count of enables. The transmit monitor therefore locks onto the falling edge of `tx_o` and then samples once just after every group of enable edges. The receive driver changes `rx_i` one nanosecond after an enable edge. Receive-full and the error flags are settled a few clocks after the mid-stop sample, so the bench holds the line idle for two more bit times before it reads status. Status, interrupt and pin levels are combinational on the registers and are sampled mid-cycle after each control write.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int DW      = 8;
  localparam int DIV_MID = 16;
  localparam int DIV_HI  = 64;
  localparam int CW      = $clog2(DIV_HI);
  localparam int FW      = DW + 4;
  localparam int LW      = $clog2(FW + 1);

  typedef struct packed {
    logic d8;
    logic par_en;
    logic par_odd;
    logic stop2;
  } fmt_t;

  function automatic fmt_t fmt_decode(input logic [2:0] c);
    fmt_t f;
    f.d8      = c[2];
    f.par_en  = ~c[2] | c[1];
    f.par_odd = c[0];
    f.stop2   = (c[2:1] == 2'b00) | (c == 3'd4);
    return f;
  endfunction

  // enables per bit minus one
  function automatic logic [CW-1:0] bit_lim(input logic [1:0] d);
    case (d)
      2'd1:    return CW'(DIV_MID - 1);
      2'd2:    return CW'(DIV_HI - 1);
      default: return '0;
    endcase
  endfunction

  function automatic logic [CW-1:0] half_lim(input logic [1:0] d);
    case (d)
      2'd1:    return CW'(DIV_MID / 2 - 1);
      2'd2:    return CW'(DIV_HI / 2 - 1);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/sa_tx.sv
module sa_tx import sa_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  input  fmt_t          fmt_i,
  input  logic [1:0]    div_i,
  output logic          busy_o,
  output logic          line_o
);
  logic [FW-1:0] sh, frame;
  logic [CW-1:0] cnt;
  logic [LW-1:0] left, nbits;
  logic          par;

  always_comb begin
    par   = (fmt_i.d8 ? ^data_i : ^data_i[DW-2:0]) ^ fmt_i.par_odd;
    frame = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DW; i++)
      if (i < DW - 1 || fmt_i.d8) frame[1+i] = data_i[i];
    if (fmt_i.par_en) frame[fmt_i.d8 ? DW + 1 : DW] = par;
    nbits = LW'(1 + (fmt_i.d8 ? DW : DW - 1) + int'(fmt_i.par_en) + (fmt_i.stop2 ? 2 : 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh <= '1; cnt <= '0; left <= '0; busy_o <= 1'b0;
    end else if (clr_i) begin
      sh <= '1; cnt <= '0; left <= '0; busy_o <= 1'b0;
    end else if (start_i) begin
      sh <= frame; cnt <= '0; left <= nbits; busy_o <= 1'b1;
    end else if (en_i && busy_o) begin
      if (cnt >= bit_lim(div_i)) begin
        cnt  <= '0;
        sh   <= {1'b1, sh[FW-1:1]};
        left <= left - LW'(1);
        if (left == LW'(1)) busy_o <= 1'b0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end
  end

  assign line_o = sh[0];

  a_r4_start_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!line_o && busy_o));
  a_r4_idle_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> line_o);
endmodule

// File: rtl/sa_rx.sv
module sa_rx import sa_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          en_i,
  input  logic          rx_i,
  input  fmt_t          fmt_i,
  input  logic [1:0]    div_i,
  output logic          done_o,
  output logic [DW-1:0] data_o,
  output logic          fe_o,
  output logic          pe_o
);
  typedef enum logic [1:0] {R_IDLE, R_START, R_BITS} rx_st_e;
  rx_st_e        st;
  logic          s1, s2, prev;
  logic [CW-1:0] cnt, lim;
  logic [LW-1:0] idx, last;
  logic [FW-1:0] b;
  logic [DW-1:0] dat;
  logic          pbit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin s1 <= 1'b1; s2 <= 1'b1; end
    else begin s1 <= rx_i; s2 <= s1; end
  end

  always_comb begin
    lim  = (st == R_START) ? half_lim(div_i) : bit_lim(div_i);
    last = LW'((fmt_i.d8 ? DW : DW - 1) + int'(fmt_i.par_en));
    dat  = fmt_i.d8 ? b[DW-1:0] : {1'b0, b[DW-2:0]};
    pbit = b[fmt_i.d8 ? DW : DW - 1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= R_IDLE; cnt <= '0; idx <= '0; prev <= 1'b1; b <= '0;
      done_o <= 1'b0; data_o <= '0; fe_o <= 1'b0; pe_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (clr_i) begin
        st <= R_IDLE; cnt <= '0; idx <= '0; prev <= 1'b1;
      end else if (en_i) begin
        prev <= s2;
        case (st)
          R_IDLE: if (prev && !s2) begin
            cnt <= '0; idx <= '0;
            st  <= (div_i == 2'd0) ? R_BITS : R_START;
          end
          R_START: if (cnt >= lim) begin
            cnt <= '0;
            st  <= s2 ? R_IDLE : R_BITS;
          end else cnt <= cnt + CW'(1);
          R_BITS: if (cnt >= lim) begin
            cnt    <= '0;
            b[idx] <= s2;
            idx    <= idx + LW'(1);
            if (idx == last) begin
              st     <= R_IDLE;
              done_o <= 1'b1;
              data_o <= dat;
              fe_o   <= !s2;
              pe_o   <= fmt_i.par_en & ((^dat ^ pbit) != fmt_i.par_odd);
            end
          end else cnt <= cnt + CW'(1);
          default: st <= R_IDLE;
        endcase
      end
    end
  end

  a_r7_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

// File: rtl/async_serial_adapter.sv
module async_serial_adapter import sa_pkg::*; (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clk_en_i,
  input  logic          sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          rx_i,
  output logic          tx_o,
  output logic          rts_o,
  input  logic          cts_n_i,
  input  logic          dcd_n_i,
  output logic          irq_o
);
  logic [DW-1:0] ctl, tdr, rdr, stat, rx_data;
  logic          tdre, rdrf, ovrn, fe, pe;
  logic          mr, rie, tie, brk, wr_tdr, rd_rdr, take;
  logic          tx_busy, tx_line, rx_done, rx_fe, rx_pe;
  fmt_t          fmt;

  assign mr     = (ctl[1:0] == 2'b11);
  assign fmt    = fmt_decode(ctl[4:2]);
  assign rie    = ctl[7];
  assign tie    = (ctl[6:5] == 2'b01);
  assign brk    = (ctl[6:5] == 2'b11) && !mr;
  assign wr_tdr = wr_i && sel_i && !mr;
  assign rd_rdr = rd_i && sel_i;
  assign take   = clk_en_i && !tdre && !cts_n_i && !tx_busy && !mr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl <= 8'h03; tdr <= '0; tdre <= 1'b1;
    end else begin
      if (wr_i && !sel_i) ctl <= wdata_i;
      if (wr_tdr) tdr <= wdata_i;
      if (mr) tdre <= 1'b1;
      else if (wr_tdr) tdre <= 1'b0;
      else if (take) tdre <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdr <= '0; rdrf <= 1'b0; ovrn <= 1'b0; fe <= 1'b0; pe <= 1'b0;
    end else if (mr) begin
      rdrf <= 1'b0; ovrn <= 1'b0; fe <= 1'b0; pe <= 1'b0;
    end else begin
      if (rd_rdr) begin
        rdrf <= 1'b0; ovrn <= 1'b0; fe <= 1'b0; pe <= 1'b0;
      end
      if (rx_done) begin
        if (rdrf && !rd_rdr) ovrn <= 1'b1;  // new char dropped
        else begin
          rdr <= rx_data; rdrf <= 1'b1; fe <= rx_fe; pe <= rx_pe;
        end
      end
    end
  end

  sa_tx u_tx (
    .clk_i, .rst_ni, .clr_i(mr), .en_i(clk_en_i), .start_i(take),
    .data_i(tdr), .fmt_i(fmt), .div_i(ctl[1:0]),
    .busy_o(tx_busy), .line_o(tx_line)
  );

  sa_rx u_rx (
    .clk_i, .rst_ni, .clr_i(mr), .en_i(clk_en_i), .rx_i,
    .fmt_i(fmt), .div_i(ctl[1:0]),
    .done_o(rx_done), .data_o(rx_data), .fe_o(rx_fe), .pe_o(rx_pe)
  );

  assign irq_o   = (rie && (rdrf || ovrn || fe || pe)) || (tie && tdre);
  assign stat    = {irq_o, pe, ovrn, fe, cts_n_i, dcd_n_i, tdre, rdrf};
  assign rdata_o = sel_i ? rdr : stat;
  assign rts_o   = (ctl[6:5] == 2'b10);
  assign tx_o    = tx_line && !brk;

  a_r1_mr_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mr |=> (tdre && !rdrf));
  a_r5_tdre_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tdre) |-> $past(wr_tdr));
  a_r9_ovrn_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovrn |-> rdrf);
  a_r10_read_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rdr && !rx_done) |=> (!rdrf && !ovrn));
endmodule

// File: tb/sim_async_serial_adapter.sv
module sim_async_serial_adapter;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic       sel = 1'b0, wr = 1'b0, rd = 1'b0, rx = 1'b1, cts_n = 1'b0, dcd_n = 1'b0;
  logic [7:0] wdata = '0, rdata;
  logic       tx, rts, irq;
  int         ecnt = 0, nvec = 0, nerr = 0, cur_n = 1;
  logic       mon_on = 1'b1;

  typedef struct { logic [11:0] f; int n; string tag; } exp_t;
  exp_t txq[$];

  async_serial_adapter u0 (
    .clk_i(clk), .rst_ni(rst_n), .clk_en_i(en), .sel_i(sel), .wr_i(wr), .rd_i(rd),
    .wdata_i(wdata), .rdata_o(rdata), .rx_i(rx), .tx_o(tx), .rts_o(rts),
    .cts_n_i(cts_n), .dcd_n_i(dcd_n), .irq_o(irq)
  );

  always #5 clk = ~clk;
  always @(negedge clk) begin
    ecnt <= (ecnt == 3) ? 0 : ecnt + 1;
    en   <= (ecnt == 2);
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_en();
    @(posedge clk);
    while (!en) @(posedge clk);
  endtask

  task automatic wr_reg(input logic s, input logic [7:0] d);
    @(negedge clk); sel = s; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic s, output logic [7:0] d);
    @(negedge clk); sel = s; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  // R3 format table: data bits, parity (0 none, 1 even, 2 odd), stop bits
  task automatic fmt_info(input logic [2:0] fm, output int d, output int p, output int s);
    case (fm)
      3'd0: begin d = 7; p = 1; s = 2; end
      3'd1: begin d = 7; p = 2; s = 2; end
      3'd2: begin d = 7; p = 1; s = 1; end
      3'd3: begin d = 7; p = 2; s = 1; end
      3'd4: begin d = 8; p = 0; s = 2; end
      3'd5: begin d = 8; p = 0; s = 1; end
      3'd6: begin d = 8; p = 1; s = 1; end
      default: begin d = 8; p = 2; s = 1; end
    endcase
  endtask

  task automatic mkframe(input logic [2:0] fm, input logic [7:0] b, output logic [11:0] f, output int n);
    int d, p, s, ones;
    fmt_info(fm, d, p, s);
    f = '1; f[0] = 1'b0; ones = 0;
    for (int i = 0; i < d; i++) begin f[1+i] = b[i]; ones += int'(b[i]); end
    if (p != 0) f[1+d] = (p == 1) ? ones[0] : ~ones[0];
    n = 1 + d + ((p != 0) ? 1 : 0) + s;
  endtask

  function automatic int div_of(input logic [1:0] c);
    return (c == 2'd1) ? 16 : (c == 2'd2) ? 64 : 1;
  endfunction

  task automatic set_ctl(input logic rie, input logic [1:0] tc, input logic [2:0] fm, input logic [1:0] dv);
    wr_reg(1'b0, {rie, tc, fm, dv});
    cur_n = div_of(dv);
  endtask

  task automatic tx_send(input logic [2:0] fm, input logic [7:0] b, input string tag);
    exp_t e;
    mkframe(fm, b, e.f, e.n);
    e.tag = tag;
    txq.push_back(e);
    wr_reg(1'b1, b);
  endtask

  task automatic drain();
    wait (txq.size() == 0);
    repeat (cur_n * 4 + 8) @(negedge clk);
  endtask

  task automatic rx_send(input logic [2:0] fm, input logic [7:0] b, input logic bad_par, input logic bad_stop);
    logic [11:0] f; int n, d, p, s;
    mkframe(fm, b, f, n);
    fmt_info(fm, d, p, s);
    if (bad_par) f[1+d] = ~f[1+d];
    if (bad_stop) f[1+d+((p != 0) ? 1 : 0)] = 1'b0;
    wait_en();
    for (int i = 0; i < n; i++) begin
      #1 rx = f[i];
      repeat (cur_n) wait_en();
    end
    #1 rx = 1'b1;
    repeat (2 * cur_n + 2) wait_en();
  endtask

  // transmit monitor: pops expected frames as the design sends them
  initial begin : tx_mon
    logic [11:0] got;
    exp_t e;
    forever begin
      @(negedge clk);
      if (mon_on && rst_n && tx === 1'b0) begin
        if (txq.size() == 0) begin
          chk("R4", "unexpected frame on tx_o", 32'(tx), 32'(1));
          repeat (64) @(negedge clk);
        end else begin
          e = txq[0];
          got = '1; got[0] = 1'b0;
          for (int i = 1; i < e.n; i++) begin
            repeat (cur_n) wait_en();
            @(negedge clk);
            got[i] = tx;
          end
          e = txq.pop_front();
          chk(e.tag, "tx frame bits", 32'(got), 32'(e.f));
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    nvec++; nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin : main
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    rd_reg(1'b0, v); chk("R1", "status after reset", 32'(v), 32'h02);
    chk("R1", "tx_o idle in reset", 32'(tx), 32'(1));
    chk("R6", "rts_o after reset", 32'(rts), 32'(0));
    chk("R12", "irq_o after reset", 32'(irq), 32'(0));
    // R1 data write ignored in master reset
    wr_reg(1'b1, 8'h55);
    repeat (40) @(negedge clk);
    rd_reg(1'b0, v); chk("R1", "status after write in reset", 32'(v), 32'h02);
    chk("R1", "tx_o after write in reset", 32'(tx), 32'(1));

    // R11 pin bits
    dcd_n = 1'b1; rd_reg(1'b0, v); chk("R11", "status with dcd high", 32'(v), 32'h06);
    cts_n = 1'b1; rd_reg(1'b0, v); chk("R11", "status with cts and dcd high", 32'(v), 32'h0E);
    cts_n = 1'b0; dcd_n = 1'b0;

    // R3 R4 every format at divide 16
    for (int fm = 0; fm < 8; fm++) begin
      set_ctl(1'b0, 2'd0, 3'(fm), 2'd1);
      tx_send(3'(fm), 8'(8'hA5 ^ (fm * 37)), "R3");
      drain();
    end
    // R2 divide 64 and divide 1
    set_ctl(1'b0, 2'd0, 3'd6, 2'd2);
    tx_send(3'd6, 8'h3B, "R2");
    drain();
    set_ctl(1'b0, 2'd0, 3'd1, 2'd0);
    tx_send(3'd1, 8'h4E, "R2");
    drain();

    // R5 clear-to-send hold
    set_ctl(1'b0, 2'd0, 3'd5, 2'd1);
    cts_n = 1'b1;
    tx_send(3'd5, 8'h3C, "R5");
    repeat (100) @(negedge clk);
    rd_reg(1'b0, v); chk("R5", "transmit-empty held clear by cts", 32'(v), 32'h08);
    chk("R5", "tx_o idle while held", 32'(tx), 32'(1));
    cts_n = 1'b0;
    drain();
    rd_reg(1'b0, v); chk("R5", "transmit-empty after send", 32'(v), 32'h02);

    // R6 rts and break
    set_ctl(1'b0, 2'd2, 3'd5, 2'd1);
    @(negedge clk); chk("R6", "rts_o in code 2", 32'(rts), 32'(1));
    mon_on = 1'b0;
    set_ctl(1'b0, 2'd3, 3'd5, 2'd1);
    repeat (2) @(negedge clk);
    chk("R6", "tx_o in break", 32'(tx), 32'(0));
    chk("R6", "rts_o in break", 32'(rts), 32'(0));
    set_ctl(1'b0, 2'd0, 3'd5, 2'd1);
    repeat (2) @(negedge clk);
    chk("R6", "tx_o after break", 32'(tx), 32'(1));
    mon_on = 1'b1;

    // R12 transmit interrupt
    set_ctl(1'b0, 2'd1, 3'd5, 2'd1);
    @(negedge clk); chk("R12", "irq_o with tx interrupt", 32'(irq), 32'(1));
    rd_reg(1'b0, v); chk("R12", "status with tx interrupt", 32'(v), 32'h82);

    // R7 R10 R12 receive 8N1 divide 16, receive interrupt on
    set_ctl(1'b1, 2'd0, 3'd5, 2'd1);
    rx_send(3'd5, 8'h96, 1'b0, 1'b0);
    rd_reg(1'b0, v); chk("R7", "status after rx 8N1", 32'(v), 32'h83);
    chk("R12", "irq_o with receive-full", 32'(irq), 32'(1));
    rd_reg(1'b1, v); chk("R7", "rx data 8N1", 32'(v), 32'h96);
    rd_reg(1'b0, v); chk("R10", "status after data read", 32'(v), 32'h02);
    chk("R12", "irq_o after data read", 32'(irq), 32'(0));

    // R7 7-bit format, top bit zero
    set_ctl(1'b1, 2'd0, 3'd2, 2'd1);
    rx_send(3'd2, 8'hD3, 1'b0, 1'b0);
    rd_reg(1'b0, v); chk("R7", "status after rx 7E1", 32'(v), 32'h83);
    rd_reg(1'b1, v); chk("R7", "rx data 7E1", 32'(v), 32'h53);

    // R8 parity error
    set_ctl(1'b1, 2'd0, 3'd6, 2'd1);
    rx_send(3'd6, 8'h5A, 1'b1, 1'b0);
    rd_reg(1'b0, v); chk("R8", "status parity error", 32'(v), 32'hC3);
    rd_reg(1'b1, v); chk("R8", "rx data with parity error", 32'(v), 32'h5A);
    rd_reg(1'b0, v); chk("R10", "parity error cleared", 32'(v), 32'h02);

    // R8 framing error
    set_ctl(1'b1, 2'd0, 3'd5, 2'd1);
    rx_send(3'd5, 8'h11, 1'b0, 1'b1);
    rd_reg(1'b0, v); chk("R8", "status framing error", 32'(v), 32'h93);
    rd_reg(1'b1, v); chk("R8", "rx data with framing error", 32'(v), 32'h11);
    rd_reg(1'b0, v); chk("R10", "framing error cleared", 32'(v), 32'h02);

    // R9 overrun
    rx_send(3'd5, 8'h21, 1'b0, 1'b0);
    rx_send(3'd5, 8'h42, 1'b0, 1'b0);
    rd_reg(1'b0, v); chk("R9", "status overrun", 32'(v), 32'hA3);
    rd_reg(1'b1, v); chk("R9", "first byte kept", 32'(v), 32'h21);
    rd_reg(1'b0, v); chk("R10", "overrun cleared", 32'(v), 32'h02);

    // R7 divide 1 and divide 64 receive
    set_ctl(1'b0, 2'd0, 3'd7, 2'd0);
    rx_send(3'd7, 8'hE7, 1'b0, 1'b0);
    rd_reg(1'b0, v); chk("R7", "status rx divide 1", 32'(v), 32'h03);
    rd_reg(1'b1, v); chk("R7", "rx data divide 1", 32'(v), 32'hE7);
    set_ctl(1'b0, 2'd0, 3'd3, 2'd2);
    rx_send(3'd3, 8'h35, 1'b0, 1'b0);
    rd_reg(1'b1, v); chk("R7", "rx data divide 64", 32'(v), 32'h35);

    // R2 master reset clears receive flags
    set_ctl(1'b0, 2'd0, 3'd5, 2'd1);
    rx_send(3'd5, 8'h0F, 1'b0, 1'b0);
    rx_send(3'd5, 8'hF0, 1'b0, 1'b0);
    rd_reg(1'b0, v); chk("R9", "status before master reset", 32'(v), 32'h23);
    wr_reg(1'b0, 8'h03);
    repeat (2) @(negedge clk);
    rd_reg(1'b0, v); chk("R2", "status after master reset", 32'(v), 32'h02);
    set_ctl(1'b0, 2'd0, 3'd5, 2'd1);
    rd_reg(1'b0, v); chk("R2", "status after leaving reset", 32'(v), 32'h02);

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule